// File: doc/BRIEF.md
# Flash Self-Programming Command Register

This block is the control and status register that software uses to start flash self-programming operations. Software writes a command bit together with an enable bit. That write arms exactly one command and opens a short countdown window. Inside the window, the next program-store instruction strobe (for page erase, page write or page-buffer clear) or program-load instruction strobe (for signature or fuse/lock reads) from the CPU fires the armed operation. If no matching strobe arrives before the countdown ends, the command disarms itself.

Page erase and page write send a one-cycle command to the flash controller. The page address is captured from the upper part of the Z pointer. The block then holds the CPU halted until the controller reports completion. Buffer clear sends a one-cycle pulse and does not halt the CPU. A special read drives a read-source select in the same cycle as the load strobe, so the load returns signature-row data or lock/fuse data. For lock/fuse reads, Z bit 0 picks which one.

Top module: `selfprog_ctl`

## Requirements
- R1: After reset, `reg_rdata` reads 0x00, `halt_req` is low, and no command pulse or read select is active.
- R2: Bits 7 and 6 of `reg_rdata` always read zero, whatever value is written to them.
- R3: A write with bit 0 (enable) set and at least one command bit set arms exactly one command. Command bits are: bit 1 erase, bit 2 write, bit 3 fuse/lock read, bit 4 buffer clear, bit 5 signature read. When several are set, priority is erase, then write, then buffer clear, then signature read, then fuse/lock read. The readback shows the armed command bit plus bit 0.
- R4: An armed store command (erase, write, buffer clear) fires on a store strobe in any of the 4 cycles after the arming write. A strobe in the same cycle as the arming write does not fire it.
- R5: A command that sees no matching strobe disarms itself. Store commands disarm after 4 cycles and special reads after 3 cycles. The register then reads 0x00, and later strobes do nothing.
- R6: A fired erase or write produces a single-cycle `erase_cmd` or `write_cmd` in the cycle after the strobe. In that cycle `page_addr` equals `z_hi` as it was at the strobe.
- R7: From the cycle after an erase or write strobe, `halt_req` stays high and the readback keeps showing the command. Both remain until the cycle in which `flash_done` is high. After that edge, halt drops and the register reads 0x00.
- R8: A fired buffer clear gives a single-cycle `buf_clr_cmd` in the cycle after the strobe, clears the register on the same edge, and never raises `halt_req`.
- R9: An armed signature read raises `rd_sig_sel` in the same cycle as a load strobe in any of the 3 cycles after the arming write. The command then disarms.
- R10: An armed fuse/lock read raises `rd_fuse_sel` on a windowed load strobe when `z_lo0` is 1, and raises `rd_lock_sel` when `z_lo0` is 0.
- R11: A store strobe while a special read is armed issues no command and no halt, and leaves the read armed.
- R12: `halt_req` is also high whenever `flash_busy` is high.
- R13: A write without the enable bit disarms any armed command. Writes while an erase or write is in progress are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data |
| spm_strobe | input | 1 | Program-store instruction strobe |
| lpm_strobe | input | 1 | Program-load instruction strobe |
| z_hi | input | ZH_W | Upper part of Z pointer (page address) |
| z_lo0 | input | 1 | Z pointer bit 0 (fuse/lock choice) |
| flash_done | input | 1 | Flash controller operation complete |
| flash_busy | input | 1 | Flash controller busy |
| halt_req | output | 1 | CPU halt request |
| erase_cmd | output | 1 | Page erase command pulse |
| write_cmd | output | 1 | Page write command pulse |
| buf_clr_cmd | output | 1 | Page buffer clear pulse |
| page_addr | output | ZH_W | Captured page address |
| rd_sig_sel | output | 1 | Load returns signature-row byte |
| rd_fuse_sel | output | 1 | Load returns fuse bits |
| rd_lock_sel | output | 1 | Load returns lock bits |

## Verification
A wrong armed state appears in the register readback on the cycle after the arming write. A countdown that runs long or short shows up as a strobe that fires at the edge of the window when it should not, or fails to fire when it should. Both are visible within five cycles. A stuck busy state leaves `halt_req` high past the `flash_done` edge. A wrong read decode raises the wrong select in the same cycle as the load strobe.

// File: rtl/selfprog_ctl.sv
module selfprog_ctl #(
  parameter int ZH_W      = 8,
  parameter int STORE_WIN = 4,
  parameter int LOAD_WIN  = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            reg_wr,
  input  logic [7:0]      reg_wdata,
  output logic [7:0]      reg_rdata,
  input  logic            spm_strobe,
  input  logic            lpm_strobe,
  input  logic [ZH_W-1:0] z_hi,
  input  logic            z_lo0,
  input  logic            flash_done,
  input  logic            flash_busy,
  output logic            halt_req,
  output logic            erase_cmd,
  output logic            write_cmd,
  output logic            buf_clr_cmd,
  output logic [ZH_W-1:0] page_addr,
  output logic            rd_sig_sel,
  output logic            rd_fuse_sel,
  output logic            rd_lock_sel
);
  localparam int MAXW = (STORE_WIN > LOAD_WIN) ? STORE_WIN : LOAD_WIN;
  localparam int CW   = $clog2(MAXW + 1);

  typedef enum logic [2:0] {A_NONE, A_ERASE, A_WRITE, A_CLEAR, A_SIG, A_FUSE} arm_t;

  arm_t            arm, next_arm;
  logic [CW-1:0]   cnt;
  logic            running;
  logic            ers_q, wr_q, clr_q;
  logic [ZH_W-1:0] addr_q;
  logic            in_win, is_store, is_load, spm_hit, lpm_hit;
  logic            unused_hi;

  assign unused_hi = ^reg_wdata[7:6];

  always_comb begin
    next_arm = A_NONE;
    if (reg_wdata[0]) begin
      if      (reg_wdata[1]) next_arm = A_ERASE;
      else if (reg_wdata[2]) next_arm = A_WRITE;
      else if (reg_wdata[4]) next_arm = A_CLEAR;
      else if (reg_wdata[5]) next_arm = A_SIG;
      else if (reg_wdata[3]) next_arm = A_FUSE;
    end
  end

  assign is_store = (arm == A_ERASE) || (arm == A_WRITE) || (arm == A_CLEAR);
  assign is_load  = (arm == A_SIG) || (arm == A_FUSE);
  assign in_win   = (arm != A_NONE) && !running && !reg_wr;
  assign spm_hit  = in_win && is_store && spm_strobe;
  assign lpm_hit  = in_win && is_load && lpm_strobe;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      arm     <= A_NONE;
      cnt     <= '0;
      running <= 1'b0;
      ers_q   <= 1'b0;
      wr_q    <= 1'b0;
      clr_q   <= 1'b0;
      addr_q  <= '0;
    end else begin
      ers_q <= 1'b0;
      wr_q  <= 1'b0;
      clr_q <= 1'b0;
      if (running) begin
        if (flash_done) begin
          running <= 1'b0;
          arm     <= A_NONE;
        end
      end else if (reg_wr) begin
        arm <= next_arm;
        cnt <= (next_arm == A_SIG || next_arm == A_FUSE) ? CW'(LOAD_WIN) : CW'(STORE_WIN);
      end else if (spm_hit) begin
        if (arm == A_CLEAR) begin
          clr_q <= 1'b1;
          arm   <= A_NONE;
        end else begin
          running <= 1'b1;
          addr_q  <= z_hi;
          ers_q   <= (arm == A_ERASE);
          wr_q    <= (arm == A_WRITE);
        end
      end else if (lpm_hit) begin
        arm <= A_NONE;
      end else if (arm != A_NONE) begin
        if (cnt <= CW'(1)) arm <= A_NONE;
        else               cnt <= cnt - CW'(1);
      end
    end
  end

  assign halt_req    = running | flash_busy;
  assign erase_cmd   = ers_q;
  assign write_cmd   = wr_q;
  assign buf_clr_cmd = clr_q;
  assign page_addr   = addr_q;
  assign rd_sig_sel  = lpm_hit && (arm == A_SIG);
  assign rd_fuse_sel = lpm_hit && (arm == A_FUSE) && z_lo0;
  assign rd_lock_sel = lpm_hit && (arm == A_FUSE) && !z_lo0;

  assign reg_rdata = {2'b00, arm == A_SIG, arm == A_CLEAR, arm == A_FUSE,
                      arm == A_WRITE, arm == A_ERASE, arm != A_NONE};

  p_cmd_after_spm_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (erase_cmd || write_cmd || buf_clr_cmd) |-> $past(spm_strobe));
  p_cnt_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (arm != A_NONE && !running) |-> (cnt >= CW'(1) && cnt <= CW'(MAXW)));
  p_one_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({erase_cmd, write_cmd, buf_clr_cmd}));
  p_pulse_short_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (erase_cmd || write_cmd) |=> !(erase_cmd || write_cmd));
  p_cmd_halts_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (erase_cmd || write_cmd) |-> halt_req);
  p_halt_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (halt_req && flash_done && !flash_busy) |=> (halt_req == flash_busy));
  p_clr_no_halt_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_clr_cmd && !flash_busy) |-> !halt_req);
  p_sel_on_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_sig_sel || rd_fuse_sel || rd_lock_sel) |-> lpm_strobe);
  p_sel_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rd_sig_sel, rd_fuse_sel, rd_lock_sel}));
endmodule

// File: tb/selfprog_ctl_test.sv
module selfprog_ctl_test;
  logic       clk = 0, rst_n = 0;
  logic       reg_wr = 0, spm_strobe = 0, lpm_strobe = 0, z_lo0 = 0;
  logic       flash_done = 0, flash_busy = 0;
  logic [7:0] reg_wdata = 0, z_hi = 0;
  logic [7:0] reg_rdata, page_addr;
  logic       halt_req, erase_cmd, write_cmd, buf_clr_cmd;
  logic       rd_sig_sel, rd_fuse_sel, rd_lock_sel;
  int total = 0, fails = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  selfprog_ctl uut (.clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .spm_strobe(spm_strobe), .lpm_strobe(lpm_strobe), .z_hi(z_hi),
    .z_lo0(z_lo0), .flash_done(flash_done), .flash_busy(flash_busy), .halt_req(halt_req),
    .erase_cmd(erase_cmd), .write_cmd(write_cmd), .buf_clr_cmd(buf_clr_cmd),
    .page_addr(page_addr), .rd_sig_sel(rd_sig_sel), .rd_fuse_sel(rd_fuse_sel),
    .rd_lock_sel(rd_lock_sel));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic write_reg(input logic [7:0] v);
    @(negedge clk); reg_wr = 1; reg_wdata = v;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic try_store(input int kind, input int d);
    logic [7:0] w, addr, seen_addr;
    int pe, pw, pc, hmax;
    bit trig;
    w = (kind == 0) ? 8'h03 : (kind == 1) ? 8'h05 : 8'h11;
    addr = 8'h40 + 8'(kind * 16 + d);
    pe = 0; pw = 0; pc = 0; hmax = 0; seen_addr = 0;
    trig = (d >= 1 && d <= 4);
    @(negedge clk); reg_wr = 1; reg_wdata = w; spm_strobe = (d == 0); z_hi = addr;
    for (int k = 1; k <= 6; k++) begin
      @(negedge clk);
      if (erase_cmd) begin pe++; seen_addr = page_addr; end
      if (write_cmd) begin pw++; seen_addr = page_addr; end
      if (buf_clr_cmd) pc++;
      if (halt_req && kind == 2) hmax = 1;
      reg_wr = 0; spm_strobe = (k == d); z_hi = (k == d) ? addr : ~addr;
    end
    check(pe == int'(trig && kind == 0), "R4 erase window", pe, int'(trig && kind == 0));
    check(pw == int'(trig && kind == 1), "R4 write window", pw, int'(trig && kind == 1));
    check(pc == int'(trig && kind == 2), "R8 clear pulse", pc, int'(trig && kind == 2));
    if (trig && kind < 2) check(seen_addr == addr, "R6 page address", seen_addr, addr);
    if (kind == 2) check(hmax == 0, "R8 clear no halt", hmax, 0);
    #1;
    if (trig && kind < 2) begin
      check(halt_req == 1, "R7 halt held", halt_req, 1);
      check(reg_rdata == w, "R7 busy readback", reg_rdata, w);
      @(negedge clk); flash_done = 1;
      @(negedge clk); flash_done = 0; #1;
      check(halt_req == 0, "R7 halt release", halt_req, 0);
      check(reg_rdata == 0, "R7 cleared on done", reg_rdata, 0);
    end else begin
      check(halt_req == 0, "R5 no halt", halt_req, 0);
      check(reg_rdata == 0, "R5 expired", reg_rdata, 0);
    end
  endtask

  task automatic try_load(input bit fuse, input bit z, input int d);
    logic [7:0] w;
    int ns, nf, nl;
    bit trig;
    w = fuse ? 8'h09 : 8'h21;
    ns = 0; nf = 0; nl = 0;
    trig = (d >= 1 && d <= 3);
    @(negedge clk); reg_wr = 1; reg_wdata = w; lpm_strobe = (d == 0); z_lo0 = z; #1;
    ns += int'(rd_sig_sel); nf += int'(rd_fuse_sel); nl += int'(rd_lock_sel);
    for (int k = 1; k <= 5; k++) begin
      @(negedge clk); reg_wr = 0; lpm_strobe = (k == d); #1;
      ns += int'(rd_sig_sel); nf += int'(rd_fuse_sel); nl += int'(rd_lock_sel);
    end
    @(negedge clk); lpm_strobe = 0; #1;
    check(ns == int'(trig && !fuse), "R9 signature select", ns, int'(trig && !fuse));
    check(nf == int'(trig && fuse && z), "R10 fuse select", nf, int'(trig && fuse && z));
    check(nl == int'(trig && fuse && !z), "R10 lock select", nl, int'(trig && fuse && !z));
    check(reg_rdata == 0, "R5 load expired", reg_rdata, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++; fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    check(reg_rdata == 0, "R1 reset rdata", reg_rdata, 0);
    check(!halt_req && !erase_cmd && !write_cmd && !buf_clr_cmd, "R1 reset outputs", halt_req, 0);
    rst_n = 1;

    for (int v = 0; v < 32; v++) begin
      logic [7:0] exp;
      exp = v[0] ? 8'h03 : v[1] ? 8'h05 : v[3] ? 8'h11 : v[4] ? 8'h21 : v[2] ? 8'h09 : 8'h00;
      write_reg({2'b11, 5'(v), 1'b1}); #1;
      check(reg_rdata == exp, "R3 priority arm", reg_rdata, exp);
      check(reg_rdata[7:6] == 0, "R2 upper bits zero", reg_rdata[7:6], 0);
      write_reg(8'hC0); #1;
      check(reg_rdata == 0, "R13 disarm without enable", reg_rdata, 0);
    end

    for (int kind = 0; kind < 3; kind++)
      for (int d = 0; d <= 5; d++) try_store(kind, d);

    for (int d = 0; d <= 4; d++) begin
      try_load(0, 0, d);
      try_load(1, 0, d);
      try_load(1, 1, d);
    end

    write_reg(8'h21);
    spm_strobe = 1;
    @(negedge clk); spm_strobe = 0; #1;
    check(!erase_cmd && !write_cmd && !buf_clr_cmd, "R11 store ignored", erase_cmd, 0);
    check(halt_req == 0, "R11 no halt", halt_req, 0);
    check(reg_rdata == 8'h21, "R11 still armed", reg_rdata, 8'h21);
    repeat (4) @(negedge clk);

    write_reg(8'h03);
    spm_strobe = 1; z_hi = 8'h5A;
    @(negedge clk); spm_strobe = 0; reg_wr = 1; reg_wdata = 8'h00;
    @(negedge clk); reg_wr = 0; #1;
    check(reg_rdata == 8'h03, "R13 write during run ignored", reg_rdata, 8'h03);
    check(halt_req == 1, "R7 halt during run", halt_req, 1);
    flash_done = 1;
    @(negedge clk); flash_done = 0; #1;
    check(halt_req == 0 && reg_rdata == 0, "R7 done release", reg_rdata, 0);

    flash_busy = 1; #1;
    check(halt_req == 1, "R12 busy halts", halt_req, 1);
    @(negedge clk); flash_busy = 0; #1;
    check(halt_req == 0, "R12 busy release", halt_req, 0);

    finished = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule